// File: doc/BRIEF.md
# Two-Output Interrupt Controller

This block collects up to 32 level-sensitive interrupt requests and steers each of them to one of two processor interrupt lines. Software arms and disarms sources through a pair of write-one registers: one sets mask bits and the other clears them, so no read-modify-write is needed. A per-source routing register selects which line a source drives. A master enable bit, living in bit 31 of the arm and disarm registers, gates both lines at once.

Only a fixed set of source positions is implemented, given by the parameter `SRC_IMPL` (default 0x000617FF: bits 0 to 10, 12, 17 and 18). In the default wiring, source 1 is the first timer, source 2 the watchdog, source 6 the general-purpose I/O block and source 7 the DMA engine. The register port is a plain synchronous write strobe with a combinational read. There is no edge capture, priority or vectoring: a request is visible exactly while its source holds it high.

Top module: `two_out_irqc`

## Requirements
- R1: After reset the mask, the master enable and the routing register are all zero, and both interrupt lines are low even with every source asserted.
- R2: A write to the arm register (offset 0x34) sets each mask bit whose written bit is 1 and leaves bits written 0 unchanged; writing 1 to bit 31 sets the master enable.
- R3: A write to the disarm register (offset 0x38) clears each mask bit whose written bit is 1 and leaves bits written 0 unchanged; writing 1 to bit 31 clears the master enable.
- R4: Reading either the arm or the disarm register returns the master enable in bit 31 and the current mask in bits 30:0.
- R5: While the master enable is 0, both interrupt lines are low and both line status registers read zero; the mask is kept.
- R6: Bit positions outside SRC_IMPL (bit 31 aside in arm and disarm) read as zero in every register and ignore writes.
- R7: The routing register (offset 0x20) is written as a whole; a routing bit of 0 sends that source to line 0 and a bit of 1 sends it to line 1.
- R8: Line n status (offset 0x00 for line 0, 0x04 for line 1) equals raw AND mask AND the sources routed to n, and interrupt line n is the OR of that status.
- R9: The raw register (offset 0x30) shows the present level of each implemented source, with no latching.
- R10: Reading an offset not listed above returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_lvl | input | 32 | Level interrupt requests, one per source bit |
| reg_wr | input | 1 | Register write strobe, taken on the rising edge |
| reg_addr | input | 8 | Register byte offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| irq_line | output | 2 | Interrupt lines to the processor, bit n is line n |

## Verification
Sources are driven as a single request, then as two requests split across the lines, then withdrawn, so a wrong routing polarity, a swapped status offset or a latched request each shows a different line pattern. Arm and disarm are written with all-zero data, with data that overlaps the current mask and with data in unimplemented positions, which separates write-one semantics from plain overwrite and from missing masking. The master enable is toggled while requests stay pending, showing that it gates the lines without disturbing the mask.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int NUM_LINES = 2;
  localparam int MASTER_BIT = DATA_W - 1;

  localparam logic [ADDR_W-1:0] OFS_LINE0  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_LINE1  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_ROUTE  = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_RAW    = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_ARM    = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_DISARM = 8'h38;
endpackage

// File: rtl/irqc_ctrl_regs.sv
module irqc_ctrl_regs
  import irqc_pkg::*;
#(
  parameter logic [DATA_W-1:0] SRC_IMPL = 32'h0006_17FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] mask,
  output logic              master_en,
  output logic [DATA_W-1:0] route
);
  localparam logic [DATA_W-1:0] KEEP = SRC_IMPL & ~(DATA_W'(1) << MASTER_BIT);

  logic arm_hit, disarm_hit, route_hit;
  logic [DATA_W-1:0] wbits;

  assign arm_hit    = wr && (addr == OFS_ARM);
  assign disarm_hit = wr && (addr == OFS_DISARM);
  assign route_hit  = wr && (addr == OFS_ROUTE);
  assign wbits      = wdata & KEEP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask      <= '0;
      master_en <= 1'b0;
      route     <= '0;
    end else begin
      if (arm_hit) begin
        mask <= mask | wbits;
        if (wdata[MASTER_BIT]) master_en <= 1'b1;
      end
      if (disarm_hit) begin
        mask <= mask & ~wbits;
        if (wdata[MASTER_BIT]) master_en <= 1'b0;
      end
      if (route_hit) route <= wbits;
    end
  end

  // R2
  arm_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == OFS_ARM) |=> ((mask & $past(wdata & KEEP)) == $past(wdata & KEEP)));
  // R3
  disarm_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == OFS_DISARM) |=> ((mask & $past(wdata & KEEP)) == '0));
  // R2
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> ($stable(mask) && $stable(master_en) && $stable(route)));
  // R6
  mask_impl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask | route) & ~KEEP) == '0);
endmodule

// File: rtl/irqc_route.sv
module irqc_route
  import irqc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DATA_W-1:0]    raw,
  input  logic [DATA_W-1:0]    mask,
  input  logic                 master_en,
  input  logic [DATA_W-1:0]    route,
  output logic [DATA_W-1:0]    line_stat [NUM_LINES],
  output logic [NUM_LINES-1:0] line
);
  logic [DATA_W-1:0] armed;
  assign armed = master_en ? (raw & mask) : '0;

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    logic [DATA_W-1:0] pick;
    assign pick         = (n == 0) ? ~route : route;
    assign line_stat[n] = armed & pick;
    assign line[n]      = |line_stat[n];
  end

  // R5
  master_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en |-> (line == '0));
  // R7
  disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_stat[0] & line_stat[1]) == '0);
  // R8
  cover_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    master_en |-> ((line_stat[0] | line_stat[1]) == (raw & mask)));
endmodule

// File: rtl/two_out_irqc.sv
module two_out_irqc
  import irqc_pkg::*;
#(
  parameter logic [DATA_W-1:0] SRC_IMPL = 32'h0006_17FF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DATA_W-1:0]    src_lvl,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic [NUM_LINES-1:0] irq_line
);
  localparam logic [DATA_W-1:0] SRC_KEEP = SRC_IMPL & ~(DATA_W'(1) << MASTER_BIT);

  logic [DATA_W-1:0] raw, mask, route;
  logic              master_en;
  logic [DATA_W-1:0] line_stat [NUM_LINES];

  assign raw = src_lvl & SRC_KEEP;

  irqc_ctrl_regs #(.SRC_IMPL(SRC_IMPL)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (reg_wr),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .mask      (mask),
    .master_en (master_en),
    .route     (route)
  );

  irqc_route u_route (
    .clk       (clk),
    .rst_n     (rst_n),
    .raw       (raw),
    .mask      (mask),
    .master_en (master_en),
    .route     (route),
    .line_stat (line_stat),
    .line      (irq_line)
  );

  always_comb begin
    unique case (reg_addr)
      OFS_LINE0:             reg_rdata = line_stat[0];
      OFS_LINE1:             reg_rdata = line_stat[1];
      OFS_ROUTE:             reg_rdata = route;
      OFS_RAW:               reg_rdata = raw;
      OFS_ARM, OFS_DISARM:   reg_rdata = mask | (DATA_W'(master_en) << MASTER_BIT);
      default:               reg_rdata = '0;
    endcase
  end

  // R9
  raw_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == OFS_RAW) |-> (reg_rdata == (src_lvl & SRC_KEEP)));
endmodule

// File: tb/two_out_irqc_test.sv
module two_out_irqc_test;
  localparam logic [31:0] IMPL = 32'h0006_17FF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_lvl = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  irq_line;

  int checks = 0;
  int errors = 0;

  two_out_irqc uut (
    .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_line(irq_line)
  );

  always #4 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    src_lvl = 32'hFFFF_FFFF;
    rd(8'h34, v); check("R1 mask after reset", v, 0);
    rd(8'h20, v); check("R1 route after reset", v, 0);
    check("R1 lines after reset", 32'(irq_line), 0);
    rd(8'h30, v); check("R9 raw all sources", v, IMPL);
    src_lvl = '0;
  endtask

  task automatic t_arm;
    logic [31:0] v;
    wr(8'h34, 32'h0000_0006);
    rd(8'h34, v); check("R2 arm sets", v, 32'h6);
    wr(8'h34, 32'h0);
    rd(8'h34, v); check("R2 zero write keeps", v, 32'h6);
    wr(8'h34, 32'h0000_0084);
    rd(8'h38, v); check("R4 read via disarm offset", v, 32'h86);
  endtask

  task automatic t_disarm;
    logic [31:0] v;
    wr(8'h38, 32'h0000_0004);
    rd(8'h34, v); check("R3 disarm clears", v, 32'h82);
    wr(8'h38, 32'h0);
    rd(8'h34, v); check("R3 zero write keeps", v, 32'h82);
  endtask

  task automatic t_unimpl;
    logic [31:0] v;
    wr(8'h34, ~IMPL & 32'h7FFF_FFFF);
    rd(8'h34, v); check("R6 unimplemented arm ignored", v, 32'h82);
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, v); check("R6 route unimplemented bits", v, IMPL);
    wr(8'h20, 32'h0);
    rd(8'h20, v); check("R7 route whole write", v, 0);
  endtask

  task automatic t_master;
    logic [31:0] v;
    src_lvl = 32'h0000_0002;
    rd(8'h00, v); check("R5 status zero with master off", v, 0);
    check("R5 lines low with master off", 32'(irq_line), 0);
    wr(8'h34, 32'h8000_0000);
    rd(8'h34, v); check("R2 master enable set", v, 32'h8000_0082);
    check("R8 line0 asserted", 32'(irq_line), 32'h1);
    rd(8'h00, v); check("R8 line0 status", v, 32'h2);
  endtask

  task automatic t_route;
    logic [31:0] v;
    wr(8'h20, 32'h0000_0002);
    check("R7 source routed to line1", 32'(irq_line), 32'h2);
    rd(8'h04, v); check("R7 line1 status", v, 32'h2);
    rd(8'h00, v); check("R7 line0 status empty", v, 0);
    src_lvl = 32'h0000_0086;
    #1 check("R8 both lines, unmasked bit dropped", 32'(irq_line), 32'h3);
    rd(8'h00, v); check("R8 line0 status split", v, 32'h80);
  endtask

  task automatic t_level;
    logic [31:0] v;
    src_lvl = 32'h0;
    #1 check("R9 lines follow level", 32'(irq_line), 0);
    rd(8'h30, v); check("R9 raw follows level", v, 0);
  endtask

  task automatic t_master_off;
    logic [31:0] v;
    src_lvl = 32'h0000_0082;
    wr(8'h38, 32'h8000_0000);
    check("R5 master off lowers lines", 32'(irq_line), 0);
    rd(8'h04, v); check("R5 line1 status zero", v, 0);
    rd(8'h38, v); check("R5 mask kept", v, 32'h82);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    rd(8'h10, v); check("R10 unmapped offset", v, 0);
    rd(8'h3C, v); check("R10 unmapped offset high", v, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_arm();
        t_disarm();
        t_unimpl();
        t_master();
        t_route();
        t_level();
        t_master_off();
        t_unmapped();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=running expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule